// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns four groups of external interrupt lines and one dedicated top-level interrupt pin into sticky request flags for an interrupt controller. Each group is a vector of lines (four by default), and a group raises its flag when any of its lines meets the group's programmed trigger condition. The trigger condition can be a rising edge, a falling edge, both edges, or a falling edge combined with a held-low level. The top-level pin triggers on a single programmable edge and has its own enable.

Software reaches two 8-bit control words over a single-cycle register bus. The bus has an address bit, a write strobe, write data and combinational read data. The bus accepts a write in the cycle its strobe is high and has no back-pressure, so no valid/ready handshake applies at this edge. Trigger-mode fields change only while the processor reports its highest interrupt level on `cpu_lvl`. The top-level polarity changes only while the top-level enable is off. Every line passes through a two-stage synchroniser. A request flag stays set until the consumer pulses the matching acknowledge input.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset both control words read 00h and every request flag is 0.
- R2: Control word 0 (address 0) holds one 2-bit trigger field per group: bits [2g+1:2g] belong to group g.
- R3: A write to control word 0 updates it only when `cpu_lvl` is 2'b11. Any other level leaves every field unchanged.
- R4: Mode 2'b00 sets the group flag on a falling edge and on every cycle that any line of the group stays low, including the cycle of an acknowledge.
- R5: Mode 2'b01 sets the group flag on a rising edge of any line only.
- R6: Mode 2'b10 sets the group flag on a falling edge of any line only.
- R7: Mode 2'b11 sets the group flag on either edge of any line.
- R8: A group flag is the OR over its lines: a single line meeting the condition sets it, while the other lines may hold any value.
- R9: Control word 1 (address 1) carries the top-level enable in bit 0 and the top-level polarity in bit 1 (1 selects rising, 0 selects falling). Bits 7:2 ignore writes and read 0. This word is not gated by `cpu_lvl`.
- R10: The polarity bit takes a written value only if the enable was 0 before the write. A single write that clears the enable and changes the polarity updates only the enable.
- R11: The top-level pin is ANDed with its enable before edge detection. While the enable is off, no top-level request arises. Clearing the enable while the gated line is high, with falling polarity selected, produces exactly one request.
- R12: A flag rises on the third rising clock edge after its input changes. It stays set until an acknowledge pulse clears it in one cycle. A new event in the same cycle as the acknowledge wins over the acknowledge.
- R13: Changing a trigger mode creates no event by itself. Only line activity, sampled against the previous synchronised value, sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 1 | Selects control word 0 or 1 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data of the addressed word |
| cpu_lvl | input | 2 | Current processor interrupt level; 2'b11 opens trigger-mode writes |
| grp_in | input | NUM_GRP*GRP_W | External lines, group g at bits [g*GRP_W +: GRP_W] |
| top_in | input | 1 | Top-level interrupt pin |
| ack_grp | input | NUM_GRP | Per-group acknowledge pulse |
| ack_top | input | 1 | Top-level acknowledge pulse |
| pend_grp | output | NUM_GRP | Per-group request flags |
| pend_top | output | 1 | Top-level request flag |

## Verification
The bench checks the held-low mode across an acknowledge. A design that treated mode 00 as edge-only would let the flag drop while the line is still low. The bench also writes the mode fields under a low processor level, and a missing level gate would let the fields change. It issues a combined clear-enable and flip-polarity write and expects the polarity to hold, then expects the one spurious request that gating the pin before the edge detector produces. A mode switch on a line already held low must raise nothing, which catches a design that compares against the mode rather than the previous sample. A random phase with a cycle model in the bench covers acknowledges that land on events, writes at random levels and multi-line activity.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SNS_LOW_FALL = 2'b00,
    SNS_RISE     = 2'b01,
    SNS_FALL     = 2'b10,
    SNS_BOTH     = 2'b11
  } sense_e;

  localparam logic CTL0_ADDR = 1'b0;
  localparam logic CTL1_ADDR = 1'b1;
  localparam int   EN_BIT    = 0;
  localparam int   POL_BIT   = 1;
  localparam logic [1:0] LVL_OPEN = 2'b11;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W       = 4,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {W{RST_VAL}};
      stage2_q <= {W{RST_VAL}};
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import eis_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int DW      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr,
  input  logic                 we,
  input  logic [DW-1:0]        wdata,
  input  logic [1:0]           cpu_lvl,
  output logic [DW-1:0]        rdata,
  output logic [2*NUM_GRP-1:0] sense_q,
  output logic                 top_en,
  output logic                 top_pol
);
  localparam int SW = 2 * NUM_GRP;

  logic wr_ctl0;
  logic wr_ctl1;
  logic lvl_open;

  assign lvl_open = (cpu_lvl == LVL_OPEN);
  assign wr_ctl0  = we && (addr == CTL0_ADDR);
  assign wr_ctl1  = we && (addr == CTL1_ADDR);

  // Trigger fields: writable only at the highest processor level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
    end else if (wr_ctl0 && lvl_open) begin
      sense_q <= wdata[SW-1:0];
    end
  end

  // Top-level controls: polarity gated by the enable value before the write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_en  <= 1'b0;
      top_pol <= 1'b0;
    end else if (wr_ctl1) begin
      top_en <= wdata[EN_BIT];
      if (!top_en) begin
        top_pol <= wdata[POL_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTL0_ADDR) begin
      rdata[SW-1:0] = sense_q;
    end else begin
      rdata[EN_BIT]  = top_en;
      rdata[POL_BIT] = top_pol;
    end
  end
endmodule

// File: rtl/eis_det.sv
module eis_det
  import eis_pkg::*;
#(
  parameter int W        = 4,
  parameter bit PREV_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  sense_e       mode,
  input  logic         ack,
  output logic         pend
);
  logic [W-1:0] prev_q;
  logic         pend_q;
  logic         rise_any;
  logic         fall_any;
  logic         low_any;
  logic         hit;

  always_comb begin
    rise_any = |(cur & ~prev_q);
    fall_any = |(~cur & prev_q);
    low_any  = |(~cur);
    case (mode)
      SNS_LOW_FALL: hit = fall_any | low_any;
      SNS_RISE:     hit = rise_any;
      SNS_FALL:     hit = fall_any;
      SNS_BOTH:     hit = rise_any | fall_any;
      default:      hit = 1'b0;
    endcase
  end

  // Previous sample follows the line in every mode, so a mode change is silent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= {W{PREV_RST}};
      pend_q <= 1'b0;
    end else begin
      prev_q <= cur;
      pend_q <= hit | (pend_q & ~ack);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int NUM_GRP  = 4,
  parameter int GRP_W    = 4,
  parameter int DW       = 8,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_addr,
  input  logic                     bus_we,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [1:0]               cpu_lvl,
  input  logic [NUM_GRP*GRP_W-1:0] grp_in,
  input  logic                     top_in,
  input  logic [NUM_GRP-1:0]       ack_grp,
  input  logic                     ack_top,
  output logic [NUM_GRP-1:0]       pend_grp,
  output logic                     pend_top
);
  localparam int IN_W = NUM_GRP * GRP_W;
  localparam int SW   = 2 * NUM_GRP;

  logic [IN_W-1:0] grp_s;
  logic            top_s;
  logic [SW-1:0]   ctl0_q;
  logic            top_en;
  logic            top_pol;
  logic            top_gated;
  sense_e          top_mode;

  eis_sync #(.W(IN_W), .RST_VAL(IDLE_LVL)) u_sync_grp (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (grp_in),
    .q     (grp_s)
  );

  eis_sync #(.W(1), .RST_VAL(IDLE_LVL)) u_sync_top (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (top_in),
    .q     (top_s)
  );

  eis_regs #(.NUM_GRP(NUM_GRP), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .cpu_lvl (cpu_lvl),
    .rdata   (bus_rdata),
    .sense_q (ctl0_q),
    .top_en  (top_en),
    .top_pol (top_pol)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    sense_e grp_mode;
    assign grp_mode = sense_e'(ctl0_q[2*g +: 2]);

    eis_det #(.W(GRP_W), .PREV_RST(IDLE_LVL)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (grp_s[g*GRP_W +: GRP_W]),
      .mode  (grp_mode),
      .ack   (ack_grp[g]),
      .pend  (pend_grp[g])
    );
  end

  // Enable gates the pin ahead of the edge detector
  assign top_gated = top_s & top_en;
  assign top_mode  = top_pol ? SNS_RISE : SNS_FALL;

  eis_det #(.W(1), .PREV_RST(1'b0)) u_det_top (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (top_gated),
    .mode  (top_mode),
    .ack   (ack_top),
    .pend  (pend_top)
  );
endmodule

// File: rtl/eis_chk.sv
module eis_chk #(
  parameter int NUM_GRP = 4,
  parameter int DW      = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_addr,
  input logic                 bus_we,
  input logic [DW-1:0]        bus_rdata,
  input logic [1:0]           cpu_lvl,
  input logic [2*NUM_GRP-1:0] ctl0_q,
  input logic                 top_en,
  input logic                 top_pol,
  input logic [NUM_GRP-1:0]   pend_grp,
  input logic [NUM_GRP-1:0]   ack_grp,
  input logic                 pend_top,
  input logic                 ack_top
);
  AST_CTL0_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 1'b0 && cpu_lvl != 2'b11) |=> $stable(ctl0_q)); // R3

  AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    top_en |=> $stable(top_pol)); // R10

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 1'b1) |-> (bus_rdata[DW-1:2] == '0)); // R9

  AST_GRP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_grp & ~ack_grp)) |=>
      ((pend_grp & $past(pend_grp & ~ack_grp)) == $past(pend_grp & ~ack_grp))); // R12

  AST_TOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_top && !ack_top) |=> pend_top); // R12

  AST_TOP_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_en && !$past(top_en) && !pend_top) |=> !pend_top); // R11
endmodule

bind ext_irq_sense eis_chk #(.NUM_GRP(NUM_GRP), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .cpu_lvl   (cpu_lvl),
  .ctl0_q    (ctl0_q),
  .top_en    (top_en),
  .top_pol   (top_pol),
  .pend_grp  (pend_grp),
  .ack_grp   (ack_grp),
  .pend_top  (pend_top),
  .ack_top   (ack_top)
);

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  localparam int NG = 4;
  localparam int GW = 4;
  localparam int IW = NG * GW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_addr = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_wdata = 8'h00;
  wire  [7:0]    bus_rdata;
  logic [1:0]    cpu_lvl = 2'b00;
  logic [IW-1:0] grp_in = '1;
  logic          top_in = 1'b1;
  logic [NG-1:0] ack_grp = '0;
  logic          ack_top = 1'b0;
  wire  [NG-1:0] pend_grp;
  wire           pend_top;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_sense u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_lvl   (cpu_lvl),
    .grp_in    (grp_in),
    .top_in    (top_in),
    .ack_grp   (ack_grp),
    .ack_top   (ack_top),
    .pend_grp  (pend_grp),
    .pend_top  (pend_top)
  );

  // Cycle model built from the requirements
  logic [IW-1:0] m_s1, m_s2, m_pv;
  logic [7:0]    m_c0;
  logic          m_en, m_pol, m_t1, m_t2, m_tp, m_pt;
  logic [NG-1:0] m_pg;

  function automatic logic grp_hit(logic [1:0] md, logic [GW-1:0] c, logic [GW-1:0] p);
    logic r, f, l;
    r = |(c & ~p);
    f = |(~c & p);
    l = |(~c);
    case (md)
      2'b00:   return f | l;
      2'b01:   return r;
      2'b10:   return f;
      default: return r | f;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [NG-1:0] h;
    logic g_now, th;
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_pv <= '1; m_c0 <= 8'h00;
      m_en <= 1'b0; m_pol <= 1'b0; m_t1 <= 1'b1; m_t2 <= 1'b1;
      m_tp <= 1'b0; m_pt <= 1'b0; m_pg <= '0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        h[g] = grp_hit(m_c0[2*g +: 2], m_s2[g*GW +: GW], m_pv[g*GW +: GW]);
      end
      g_now = m_t2 & m_en;
      th = m_pol ? (g_now & ~m_tp) : (~g_now & m_tp);
      m_pg <= h | (m_pg & ~ack_grp);
      m_pt <= th | (m_pt & ~ack_top);
      m_s1 <= grp_in; m_s2 <= m_s1; m_pv <= m_s2;
      m_t1 <= top_in; m_t2 <= m_t1; m_tp <= g_now;
      if (bus_we && bus_addr == 1'b0 && cpu_lvl == 2'b11) m_c0 <= bus_wdata;
      if (bus_we && bus_addr == 1'b1) begin
        m_en <= bus_wdata[0];
        if (!m_en) m_pol <= bus_wdata[1];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic a, logic [7:0] e);
    bus_addr = a;
    #1;
    chk(tag, 32'(bus_rdata), 32'(e));
  endtask

  task automatic ack_g(int g);
    ack_grp = NG'(1 << g);
    @(negedge clk);
    ack_grp = '0;
  endtask

  task automatic ack_t();
    ack_top = 1'b1;
    @(negedge clk);
    ack_top = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1
    rd_chk("R1 ctl0 reset", 1'b0, 8'h00);
    rd_chk("R1 ctl1 reset", 1'b1, 8'h00);
    chk("R1 pend reset", {pend_top, pend_grp}, 0);

    // R3: level gate on trigger fields
    cpu_lvl = 2'b01; wr(1'b0, 8'hFF);
    rd_chk("R3 write at level 01 ignored", 1'b0, 8'h00);
    cpu_lvl = 2'b10; wr(1'b0, 8'h5A);
    rd_chk("R3 write at level 10 ignored", 1'b0, 8'h00);
    cpu_lvl = 2'b11; wr(1'b0, 8'hE4);   // g3=11 g2=10 g1=01 g0=00
    rd_chk("R2 R3 write at level 11", 1'b0, 8'hE4);
    cpu_lvl = 2'b00;

    // R5 + R12 latency
    grp_in[6] = 1'b0; cyc(4);
    chk("R5 fall ignored in rise mode", pend_grp, 0);
    grp_in[6] = 1'b1; cyc(2);
    chk("R12 not yet after two edges", pend_grp, 0);
    cyc(1);
    chk("R5 rise sets group 1", pend_grp, 4'b0010);
    ack_g(1);
    chk("R12 ack clears", pend_grp, 0);

    // R6
    grp_in[8] = 1'b0; cyc(3);
    chk("R6 fall sets group 2", pend_grp, 4'b0100);
    ack_g(2);
    grp_in[8] = 1'b1; cyc(4);
    chk("R6 rise ignored", pend_grp, 0);

    // R7
    grp_in[12] = 1'b0; cyc(3);
    chk("R7 fall sets group 3", pend_grp, 4'b1000);
    ack_g(3);
    chk("R7 cleared", pend_grp, 0);
    grp_in[12] = 1'b1; cyc(3);
    chk("R7 rise sets group 3", pend_grp, 4'b1000);
    ack_g(3);

    // R8: one line rises while another stays low
    grp_in[5:4] = 2'b00; cyc(4);
    chk("R8 lows in rise mode quiet", pend_grp, 0);
    grp_in[5] = 1'b1; cyc(3);
    chk("R8 any line sets group", pend_grp, 4'b0010);
    ack_g(1);

    // R13: switch group 1 to falling with a line already low
    cpu_lvl = 2'b11; wr(1'b0, 8'hE8); cpu_lvl = 2'b00;
    cyc(4);
    chk("R13 mode change raises nothing", pend_grp, 0);
    grp_in[4] = 1'b1; cyc(4);
    chk("R6 rise ignored after mode change", pend_grp, 0);
    cpu_lvl = 2'b11; wr(1'b0, 8'hE4); cpu_lvl = 2'b00;

    // R4: held low re-sets across acknowledge
    grp_in[3] = 1'b0; cyc(3);
    chk("R4 low sets group 0", pend_grp, 4'b0001);
    ack_g(0);
    chk("R4 R12 held low wins over ack", pend_grp, 4'b0001);
    grp_in[3] = 1'b1; cyc(3);
    ack_g(0);
    chk("R4 released then cleared", pend_grp, 0);

    // R9 / R10 / R11: top-level pin
    wr(1'b1, 8'hFE);
    rd_chk("R9 reserved bits read zero", 1'b1, 8'h02);
    rd_chk("R9 ctl0 untouched", 1'b0, 8'hE4);
    top_in = 1'b0; cyc(4); top_in = 1'b1; cyc(4);
    chk("R11 disabled pin quiet", pend_top, 0);
    wr(1'b1, 8'h00);
    rd_chk("R10 pol writable while disabled", 1'b1, 8'h00);
    wr(1'b1, 8'h01);
    rd_chk("R9 enable set", 1'b1, 8'h01);
    cyc(3);
    chk("R11 enabling high pin under falling quiet", pend_top, 0);
    top_in = 1'b0; cyc(2);
    chk("R12 top not yet", pend_top, 0);
    cyc(1);
    chk("R11 falling edge sets top", pend_top, 1);
    ack_t();
    chk("R12 top ack clears", pend_top, 0);
    top_in = 1'b1; cyc(4);
    chk("R11 rise ignored under falling", pend_top, 0);
    wr(1'b1, 8'h03);
    rd_chk("R10 pol held while enabled", 1'b1, 8'h01);
    wr(1'b1, 8'h02);
    rd_chk("R10 combined write updates only enable", 1'b1, 8'h00);
    cyc(1);
    chk("R11 spurious request on disable", pend_top, 1);
    ack_t();
    chk("R11 spurious cleared", pend_top, 0);
    cyc(3);
    chk("R11 only one spurious request", pend_top, 0);
    wr(1'b1, 8'h02);
    rd_chk("R10 pol takes value once disabled", 1'b1, 8'h02);

    // Random phase against the cycle model (R4-R8, R11-R13)
    for (int i = 0; i < 3000; i++) begin
      chk("R12 random group flags", pend_grp, m_pg);
      chk("R11 random top flag", pend_top, m_pt);
      if ($urandom % 3 == 0) grp_in[$urandom % IW] ^= 1'b1;
      if ($urandom % 6 == 0) top_in = ~top_in;
      ack_grp = ($urandom % 4 == 0) ? NG'($urandom) : '0;
      ack_top = ($urandom % 5 == 0);
      cpu_lvl = 2'($urandom);
      bus_we = ($urandom % 12 == 0);
      bus_addr = 1'($urandom);
      bus_wdata = 8'($urandom);
      @(negedge clk);
    end
    bus_we = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule